// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit for a multi-cycle processor datapath that shares one memory port and one ALU across all the steps of an instruction. Each clock cycle it emits the full set of mux selects and write enables that the datapath needs for the current step. It then picks the next step from the current step and the 6-bit opcode held in the instruction register.

Every instruction starts with a fetch step and a decode/register-read step. After that the sequence splits by instruction class. Loads and stores compute an address, then access memory. R-type instructions execute, then write their result back. A conditional branch and a jump each finish in one further step. Loads alone take a final register write-back step. The outputs depend only on the state, so they are glitch-free decodes of a registered value. The one exception is the combined PC load enable, which also looks at the ALU zero flag.

The reset input is asynchronous and active-low. The chip's reset tree is expected to release it in step with the clock.

Top module: `mcc_fsm`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, the outputs show the fetch step.
- R2: Fetch step outputs: `mem_rd`, `ir_wr` and `pc_wr` are 1, `addr_sel`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_op`=0 (add), `pc_src`=0 (ALU result), and all other enables are 0.
- R3: The decode step always follows fetch. Its outputs are `alu_a_sel`=0, `alu_b_sel`=3 (sign-extended offset shifted by 2) and `alu_op`=0, with every write and memory enable at 0.
- R4: Opcode 0x23 (load) runs in 5 cycles: fetch, decode, address step, memory-read step, write-back step, then fetch. The outputs of these steps are as follows. Address step: `alu_a_sel`=1, `alu_b_sel`=2, `alu_op`=0. Memory-read step: `mem_rd`=1, `addr_sel`=1. Write-back step: `reg_wr`=1, `dst_sel`=0 (rt), `wdata_sel`=1 (memory data).
- R5: Opcode 0x2B (store) runs in 4 cycles: fetch, decode, address step, then a memory-write step with `mem_wr`=1 and `addr_sel`=1, then fetch.
- R6: Opcode 0x00 (R-type) runs in 4 cycles. The execute step has `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=2 (function field). The completion step has `reg_wr`=1, `dst_sel`=1 (rd), `wdata_sel`=0 (ALU register). Fetch follows.
- R7: Opcode 0x04 (branch-if-equal) runs in 3 cycles. The branch step has `pc_wr_cond`=1, `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1 (subtract), `pc_src`=1 (ALU register). Fetch follows.
- R8: `pc_load` is 1 in the fetch and jump steps. It equals `zero` in the branch step and is 0 in every other step.
- R9: Opcode 0x02 (jump) runs in 3 cycles. The jump step has `pc_wr`=1 and `pc_src`=2 (jump target). Fetch follows.
- R10: Any other opcode returns to fetch straight after decode.
- R11: `mem_rd` and `mem_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by zero |
| pc_load | output | 1 | Final PC load enable |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| dst_sel | output | 1 | Register destination: 0 rt, 1 rd |
| wdata_sel | output | 1 | Register data: 0 ALU register, 1 memory data |
| reg_wr | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 0 B, 1 four, 2 offset, 3 offset<<2 |
| alu_op | output | 2 | ALU class: 0 add, 1 subtract, 2 function field |
| pc_src | output | 2 | PC source: 0 ALU, 1 ALU register, 2 jump target |

## Verification
The checker watches several rules on every cycle. Memory read and write never overlap. A fetch is always followed by decode. Each completing step is followed by a fresh fetch. A load write-back is always preceded by a memory read from the computed address. The PC load tracks the zero flag during the branch step. The exact step sequence and latency of each instruction class, the outputs of each step, the fall-back on an unknown opcode, and a reset arriving mid-instruction can only be shown by the bench's directed scenarios.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LDMEM, ST_LDWB,
    ST_STMEM, ST_REXE, ST_RWB, ST_BRANCH, ST_JUMP
  } step_e;

  typedef enum logic [1:0] {BSEL_REG = 2'd0, BSEL_FOUR = 2'd1, BSEL_OFS = 2'd2, BSEL_OFS4 = 2'd3} bsel_e;
  typedef enum logic [1:0] {AOP_ADD = 2'd0, AOP_SUB = 2'd1, AOP_FUNCT = 2'd2} aop_e;
  typedef enum logic [1:0] {PSRC_ALU = 2'd0, PSRC_AREG = 2'd1, PSRC_JMP = 2'd2} psrc_e;

  typedef struct packed {
    logic  pc_wr;
    logic  pc_wr_cond;
    logic  addr_sel;
    logic  mem_rd;
    logic  mem_wr;
    logic  ir_wr;
    logic  dst_sel;
    logic  wdata_sel;
    logic  reg_wr;
    logic  alu_a_sel;
    bsel_e alu_b_sel;
    aop_e  alu_op;
    psrc_e pc_src;
  } ctrl_t;
endpackage

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
(
  input  step_e            cur,
  input  logic [OPC_W-1:0] opcode,
  output step_e            nxt
);
  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_ADDR;
        else if (opcode == OPC_RTYPE)                  nxt = ST_REXE;
        else if (opcode == OPC_BEQ)                    nxt = ST_BRANCH;
        else if (opcode == OPC_JUMP)                   nxt = ST_JUMP;
        else                                           nxt = ST_FETCH;
      end
      ST_ADDR:   nxt = (opcode == OPC_LOAD) ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_REXE:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
  import mcc_pkg::*;
(
  input  step_e cur,
  output ctrl_t ctl
);
  always_comb begin
    ctl = '{pc_wr: 1'b0, pc_wr_cond: 1'b0, addr_sel: 1'b0, mem_rd: 1'b0,
            mem_wr: 1'b0, ir_wr: 1'b0, dst_sel: 1'b0, wdata_sel: 1'b0,
            reg_wr: 1'b0, alu_a_sel: 1'b0, alu_b_sel: BSEL_REG,
            alu_op: AOP_ADD, pc_src: PSRC_ALU};
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = BSEL_FOUR;
      end
      ST_DECODE: ctl.alu_b_sel = BSEL_OFS4;
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_OFS;
      end
      ST_LDMEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.reg_wr    = 1'b1;
        ctl.wdata_sel = 1'b1;
      end
      ST_STMEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_op    = AOP_FUNCT;
      end
      ST_RWB: begin
        ctl.reg_wr  = 1'b1;
        ctl.dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctl.pc_wr_cond = 1'b1;
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op     = AOP_SUB;
        ctl.pc_src     = PSRC_AREG;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PSRC_JMP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcc_fsm.sv
module mcc_fsm
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic       zero,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       pc_load,
  output logic       addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_wr,
  output logic       dst_sel,
  output logic       wdata_sel,
  output logic       reg_wr,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op,
  output logic [1:0] pc_src
);
  step_e state_q, state_d;
  ctrl_t ctl;

  mcc_next next_i (.cur(state_q), .opcode(opcode), .nxt(state_d));
  mcc_outdec dec_i (.cur(state_q), .ctl(ctl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign pc_load    = ctl.pc_wr | (ctl.pc_wr_cond & zero);
  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_wr      = ctl.ir_wr;
  assign dst_sel    = ctl.dst_sel;
  assign wdata_sel  = ctl.wdata_sel;
  assign reg_wr     = ctl.reg_wr;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign alu_op     = ctl.alu_op;
  assign pc_src     = ctl.pc_src;
endmodule

// File: rtl/mcc_fsm_chk.sv
module mcc_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       zero,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       pc_load,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       reg_wr,
  input logic       wdata_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] pc_src
);
  // R11: one memory operation per cycle
  assert_mem_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3: decode always follows fetch
  assert_decode_after_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (!ir_wr && alu_b_sel == 2'd3 && !pc_wr && !mem_rd));

  // R7: every completing step hands back to fetch
  assert_done_refetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || mem_wr || pc_wr_cond || (pc_wr && pc_src == 2'd2)) |=> ir_wr);

  // R4: load write-back preceded by a data read
  assert_ldwb_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wdata_sel) |-> $past(mem_rd && addr_sel));

  // R8: branch load follows the zero flag
  assert_branch_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_cond && zero) |-> pc_load);
  assert_branch_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_cond && !zero) |-> !pc_load);
endmodule

bind mcc_fsm mcc_fsm_chk chk_i (
  .clk(clk), .rst_n(rst_n), .zero(zero), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .pc_load(pc_load), .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .ir_wr(ir_wr), .reg_wr(reg_wr), .wdata_sel(wdata_sel), .alu_b_sel(alu_b_sel),
  .pc_src(pc_src)
);

// File: tb/mcc_fsm_tb_top.sv
`timescale 1ns/1ps
module mcc_fsm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic zero = 1'b0;
  logic pc_wr, pc_wr_cond, pc_load, addr_sel, mem_rd, mem_wr, ir_wr;
  logic dst_sel, wdata_sel, reg_wr, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mcc_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_load(pc_load),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .dst_sel(dst_sel), .wdata_sel(wdata_sel), .reg_wr(reg_wr),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src)
  );

  // {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,dst_sel,wdata_sel,reg_wr,alu_a_sel,b[1:0],op[1:0],src[1:0]}
  localparam logic [15:0] E_FETCH  = {10'b1001010000, 2'd1, 2'd0, 2'd0};
  localparam logic [15:0] E_DECODE = {10'b0000000000, 2'd3, 2'd0, 2'd0};
  localparam logic [15:0] E_ADDR   = {10'b0000000001, 2'd2, 2'd0, 2'd0};
  localparam logic [15:0] E_LDMEM  = {10'b0011000000, 2'd0, 2'd0, 2'd0};
  localparam logic [15:0] E_LDWB   = {10'b0000000110, 2'd0, 2'd0, 2'd0};
  localparam logic [15:0] E_STMEM  = {10'b0010100000, 2'd0, 2'd0, 2'd0};
  localparam logic [15:0] E_REXE   = {10'b0000000001, 2'd0, 2'd2, 2'd0};
  localparam logic [15:0] E_RWB    = {10'b0000001010, 2'd0, 2'd0, 2'd0};
  localparam logic [15:0] E_BRANCH = {10'b0100000001, 2'd0, 2'd1, 2'd1};
  localparam logic [15:0] E_JUMP   = {10'b1000000000, 2'd0, 2'd0, 2'd2};

  function automatic logic [15:0] sig();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, dst_sel,
            wdata_sel, reg_wr, alu_a_sel, alu_b_sel, alu_op, pc_src};
  endfunction

  task automatic chk_sig(input logic [15:0] exp, input string req);
    total++;
    if (sig() !== exp) begin
      bad++;
      $display("FAIL %s: controls actual=%h expected=%h", req, sig(), exp);
    end
  endtask

  task automatic chk_load(input logic exp, input string req);
    total++;
    if (pc_load !== exp) begin
      bad++;
      $display("FAIL %s: pc_load actual=%b expected=%b", req, pc_load, exp);
    end
  endtask

  // sample 2 ns after the rising edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic fetch_decode();
    chk_sig(E_FETCH, "R2");
    chk_load(1'b1, "R8");
    step();
    chk_sig(E_DECODE, "R3");
    chk_load(1'b0, "R8");
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    chk_sig(E_FETCH, "R1");
    step();
    rst_n = 1'b1;
    chk_sig(E_FETCH, "R1");
  endtask

  task automatic t_load();
    opcode = 6'h23;
    fetch_decode();
    chk_sig(E_ADDR, "R4");
    step();
    chk_sig(E_LDMEM, "R4");
    step();
    chk_sig(E_LDWB, "R4");
    step();
    chk_sig(E_FETCH, "R4");
  endtask

  task automatic t_store();
    opcode = 6'h2B;
    fetch_decode();
    chk_sig(E_ADDR, "R5");
    step();
    chk_sig(E_STMEM, "R5");
    step();
    chk_sig(E_FETCH, "R5");
  endtask

  task automatic t_rtype();
    opcode = 6'h00;
    fetch_decode();
    chk_sig(E_REXE, "R6");
    step();
    chk_sig(E_RWB, "R6");
    step();
    chk_sig(E_FETCH, "R6");
  endtask

  task automatic t_branch(input logic z);
    opcode = 6'h04;
    zero = z;
    fetch_decode();
    chk_sig(E_BRANCH, "R7");
    chk_load(z, "R8");
    zero = ~z;
    #1;
    chk_load(~z, "R8");
    step();
    zero = 1'b0;
    chk_sig(E_FETCH, "R7");
  endtask

  task automatic t_jump();
    opcode = 6'h02;
    fetch_decode();
    chk_sig(E_JUMP, "R9");
    chk_load(1'b1, "R8");
    step();
    chk_sig(E_FETCH, "R9");
  endtask

  task automatic t_unknown(input logic [5:0] op);
    opcode = op;
    fetch_decode();
    chk_sig(E_FETCH, "R10");
  endtask

  task automatic t_reset_midway();
    opcode = 6'h23;
    fetch_decode();
    chk_sig(E_ADDR, "R4");
    #1;
    rst_n = 1'b0;
    #1;
    chk_sig(E_FETCH, "R1");
    step();
    rst_n = 1'b1;
    chk_sig(E_FETCH, "R1");
    step();
    chk_sig(E_DECODE, "R3");
    opcode = 6'h00;
    step();
    chk_sig(E_REXE, "R6");
    step();
    step();
  endtask

  initial begin
    #2;
    t_reset();
    t_load();
    t_store();
    t_rtype();
    t_branch(1'b1);
    t_branch(1'b0);
    t_jump();
    t_unknown(6'h3F);
    t_unknown(6'h08);
    t_load();
    t_reset_midway();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule